// File: doc/BRIEF.md
# Shared-Bus Ownership Arbiter

This block decides which of up to sixteen managers owns the address phase of a single shared AHB bus. Each manager raises a request line and, when needed, a lock line. The arbiter watches the transfer type, the burst type, the ready signal and the response signal on the shared bus. It moves ownership only at the end of a transfer and never breaks up a locked sequence or a fixed-length burst. Its outputs are a one-hot grant vector, a registered owner number and a registered locked-access flag for the slaves.

The winner is picked by one of two schemes, chosen when the block is elaborated: a static ranking, or a rotating ranking that starts after the current owner. The block also keeps a second owner register for the data phase. An error response that lands just after ownership has moved is therefore steered to the manager that issued the failing transfer, and not to the manager that has just been granted.

Top module: `bus_owner_arbiter`

## Requirements
- R1: The manager count parameter must lie between 1 and 16. After reset and at all times, exactly one grant bit is high, and `hmaster` equals the index of that bit. Out of reset the owner is manager 0.
- R2: Ownership, `hmaster` and `hmastlock` change only on a rising clock edge at which `hready` is 1. While `hready` is 0 they hold.
- R3: With `ARB_MODE`=0 (static), the requesting manager with the lowest index wins an arbitration.
- R4: With `ARB_MODE`=1 (rotating), the search starts at the current owner plus one and wraps around. The current owner ranks last.
- R5: When no manager requests and nothing holds the bus, ownership parks on manager 0.
- R6: If the current owner's lock input is 1 at an edge with `hready` high, that owner keeps the bus. At that edge `hmastlock` takes the value of the lock input of the owner chosen at that edge.
- R7: A fixed-length burst (`hburst` 2 or 3 = 4 beats, 4 or 5 = 8 beats, 6 or 7 = 16 beats) starts with an accepted NONSEQ (`htrans`=2). Ownership is held until the burst's last SEQ beat (`htrans`=3) has been accepted. Transfers are accepted only when `hready` is 1.
- R8: An ERROR response (`hresp`=1 with `hready`=1) ends the burst hold at that edge, so arbitration runs again at once.
- R9: On every edge with `hready` high, `dp_master` takes the `hmaster` value from before that edge. `err_to` is one-hot on bit `dp_master` while `hresp` and `hready` are both 1, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | N_MGR | Bus request, one per manager |
| lock | input | N_MGR | Locked-sequence request, one per manager |
| htrans | input | 2 | Transfer type on the shared bus (0 idle, 1 busy, 2 nonseq, 3 seq) |
| hburst | input | 3 | Burst type on the shared bus |
| hready | input | 1 | Transfer completes this cycle |
| hresp | input | 1 | Response: 0 OKAY, 1 ERROR |
| grant | output | N_MGR | One-hot address-phase grant |
| hmaster | output | 4 | Registered address-phase owner number |
| hmastlock | output | 1 | Registered locked-access indication |
| dp_master | output | 4 | Data-phase owner number |
| err_to | output | N_MGR | One-hot error steering to the data-phase owner |

## Verification
`grant`, `hmaster`, `hmastlock` and `dp_master` are due one clock edge after the inputs that decide them. The bench drives inputs on the falling edge, steps its own reference model at that moment, and compares the registered outputs at the next falling edge. `err_to` is combinational from `hresp`, `hready` and the current data-phase owner. It is checked a moment after the inputs are driven, before the edge that could move that owner. Two instances, one per ranking scheme, run on the same stimulus, so every cycle checks both schemes.

// File: rtl/arb_pkg.sv
package arb_pkg;

   localparam int IDX_W = 4;
   localparam int MAX_MGR = 16;

   localparam logic [1:0] TR_IDLE   = 2'd0;
   localparam logic [1:0] TR_BUSY   = 2'd1;
   localparam logic [1:0] TR_NONSEQ = 2'd2;
   localparam logic [1:0] TR_SEQ    = 2'd3;

   localparam int BEAT_W = 5;

   // beats in a fixed-length burst; zero for single or open-ended kinds
   function automatic logic [BEAT_W-1:0] burst_beats(input logic [2:0] kind);
      logic [BEAT_W-1:0] n;
      case (kind)
         3'd2, 3'd3: n = 5'd4;
         3'd4, 3'd5: n = 5'd8;
         3'd6, 3'd7: n = 5'd16;
         default:    n = 5'd0;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/arb_pick.sv
module arb_pick
   import arb_pkg::*;
#(
   parameter int N_MGR    = 4,
   parameter int ARB_MODE = 0
) (
   input  logic [N_MGR-1:0] req,
   input  logic [IDX_W-1:0] last,
   output logic [IDX_W-1:0] win,
   output logic             any
);

   assign any = |req;

   generate
      if (ARB_MODE == 0) begin : g_static
         always_comb begin
            win = '0;
            for (int i = N_MGR - 1; i >= 0; i--) begin
               if (req[i]) win = IDX_W'(i);
            end
         end
      end else begin : g_rotate
         // descending k: the smallest distance past the owner is written last
         always_comb begin
            win = '0;
            for (int k = N_MGR; k >= 1; k--) begin
               if (req[(int'(last) + k) % N_MGR]) win = IDX_W'((int'(last) + k) % N_MGR);
            end
         end
      end
   endgenerate

   always_comb begin
      if (any) begin
         a_win_requests_r3: assert (req[win]);
      end
   end

endmodule

// File: rtl/arb_burst_track.sv
module arb_burst_track
   import arb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hready,
   input  logic [1:0] htrans,
   input  logic [2:0] hburst,
   input  logic       err,
   output logic       hold
);

   logic [BEAT_W-1:0] left_q;
   logic [BEAT_W-1:0] left_nx;
   logic [BEAT_W-1:0] len;

   assign len = burst_beats(hburst);

   always_comb begin
      left_nx = left_q;
      if (err) begin
         left_nx = '0;
      end else if (htrans == TR_NONSEQ && len != '0) begin
         left_nx = len - 5'd1;
      end else if (htrans == TR_SEQ && left_q != '0) begin
         left_nx = left_q - 5'd1;
      end
   end

   assign hold = (left_nx != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      left_q <= '0;
      else if (hready) left_q <= left_nx;
   end

   p_left_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      left_q <= 5'd15);

   p_err_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hready && err) |=> (left_q == '0));

   p_stall_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !hready |=> $stable(left_q));

endmodule

// File: rtl/bus_owner_arbiter.sv
module bus_owner_arbiter
   import arb_pkg::*;
#(
   parameter int N_MGR    = 4,
   parameter int ARB_MODE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_MGR-1:0] req,
   input  logic [N_MGR-1:0] lock,
   input  logic [1:0]       htrans,
   input  logic [2:0]       hburst,
   input  logic             hready,
   input  logic             hresp,
   output logic [N_MGR-1:0] grant,
   output logic [IDX_W-1:0] hmaster,
   output logic             hmastlock,
   output logic [IDX_W-1:0] dp_master,
   output logic [N_MGR-1:0] err_to
);

   generate
      if (N_MGR < 1 || N_MGR > MAX_MGR) begin : g_bad_count
         $error("bus_owner_arbiter: N_MGR out of range");
      end
      if (ARB_MODE != 0 && ARB_MODE != 1) begin : g_bad_mode
         $error("bus_owner_arbiter: ARB_MODE must be 0 or 1");
      end
   endgenerate

   logic [N_MGR-1:0] grant_q;
   logic [IDX_W-1:0] owner_q;
   logic             mlock_q;
   logic [IDX_W-1:0] dp_q;

   logic             err_now;
   logic             burst_hold;
   logic             lock_own;
   logic             keep;
   logic [IDX_W-1:0] win;
   logic             any_req;
   logic [IDX_W-1:0] next_owner;
   logic             next_lock;

   assign err_now = hresp & hready;

   arb_pick #(.N_MGR(N_MGR), .ARB_MODE(ARB_MODE)) u_pick (
      .req  (req),
      .last (owner_q),
      .win  (win),
      .any  (any_req)
   );

   arb_burst_track u_burst (
      .clk    (clk),
      .rst_n  (rst_n),
      .hready (hready),
      .htrans (htrans),
      .hburst (hburst),
      .err    (err_now),
      .hold   (burst_hold)
   );

   always_comb begin
      lock_own = 1'b0;
      for (int i = 0; i < N_MGR; i++) begin
         if (owner_q == IDX_W'(i)) lock_own = lock[i];
      end
   end

   assign keep = lock_own | burst_hold;

   always_comb begin
      if (keep)         next_owner = owner_q;
      else if (any_req) next_owner = win;
      else              next_owner = '0;
   end

   always_comb begin
      next_lock = 1'b0;
      for (int i = 0; i < N_MGR; i++) begin
         if (next_owner == IDX_W'(i)) next_lock = lock[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_q <= N_MGR'(1);
         owner_q <= '0;
         mlock_q <= 1'b0;
         dp_q    <= '0;
      end else if (hready) begin
         grant_q <= N_MGR'(1) << next_owner;
         owner_q <= next_owner;
         mlock_q <= next_lock;
         dp_q    <= owner_q;
      end
   end

   always_comb begin
      err_to = '0;
      for (int i = 0; i < N_MGR; i++) begin
         if (err_now && dp_q == IDX_W'(i)) err_to[i] = 1'b1;
      end
   end

   assign grant     = grant_q;
   assign hmaster   = owner_q;
   assign hmastlock = mlock_q;
   assign dp_master = dp_q;

   p_grant_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(grant_q) == 1);

   p_grant_matches_r1: assert property (@(posedge clk) disable iff (!rst_n)
      grant_q[owner_q]);

   p_no_move_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !hready |=> ($stable(owner_q) && $stable(grant_q) && $stable(mlock_q)));

   p_park_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hready && !keep && req == '0) |=> (owner_q == '0));

   p_lock_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hready && lock_own) |=> (owner_q == $past(owner_q)));

   p_burst_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hready && burst_hold) |=> (owner_q == $past(owner_q)));

   p_dp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hready |=> (dp_q == $past(owner_q)));

   p_err_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(err_to) == (err_now ? 1 : 0));

endmodule

// File: tb/tb_bus_owner_arbiter.sv
`timescale 1ns/1ps
module tb_bus_owner_arbiter;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic [N-1:0] lock = '0;
   logic [1:0]   htrans = 2'd0;
   logic [2:0]   hburst = 3'd0;
   logic         hready = 1'b1;
   logic         hresp = 1'b0;

   logic [N-1:0] g0, g1, e0, e1;
   logic [3:0]   m0, m1, d0, d1;
   logic         l0, l1;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   string tag = "";

   // reference state per scheme: [0] static, [1] rotating
   int own[2];
   int dpm[2];
   int beats[2];
   bit mlk[2];

   always #4 clk = ~clk;

   bus_owner_arbiter #(.N_MGR(N), .ARB_MODE(0)) dut (
      .clk(clk), .rst_n(rst_n), .req(req), .lock(lock), .htrans(htrans),
      .hburst(hburst), .hready(hready), .hresp(hresp), .grant(g0),
      .hmaster(m0), .hmastlock(l0), .dp_master(d0), .err_to(e0));

   bus_owner_arbiter #(.N_MGR(N), .ARB_MODE(1)) dut_rr (
      .clk(clk), .rst_n(rst_n), .req(req), .lock(lock), .htrans(htrans),
      .hburst(hburst), .hready(hready), .hresp(hresp), .grant(g1),
      .hmaster(m1), .hmastlock(l1), .dp_master(d1), .err_to(e1));

   task automatic chk(input string r, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", r, what, act, exp, $time);
      end
   endtask

   function automatic int beats_of(input logic [2:0] k);
      if (k == 3'd2 || k == 3'd3) return 4;
      if (k == 3'd4 || k == 3'd5) return 8;
      if (k == 3'd6 || k == 3'd7) return 16;
      return 0;
   endfunction

   function automatic int pick(input int mode, input int cur, input logic [N-1:0] r);
      if (r == '0) return 0;
      if (mode == 0) begin
         for (int i = 0; i < N; i++) if (r[i]) return i;
      end else begin
         for (int k = 1; k <= N; k++) if (r[(cur + k) % N]) return (cur + k) % N;
      end
      return 0;
   endfunction

   task automatic model_reset();
      for (int s = 0; s < 2; s++) begin
         own[s] = 0; dpm[s] = 0; beats[s] = 0; mlk[s] = 0;
      end
   endtask

   // advance reference state with the inputs now on the pins (R2 R5 R6 R7 R8 R9)
   task automatic model_step();
      bit err;
      int nb, nxt;
      err = hresp && hready;
      for (int s = 0; s < 2; s++) begin
         if (hready) begin
            nb = beats[s];
            if (err) nb = 0;
            else if (htrans == 2'd2 && beats_of(hburst) != 0) nb = beats_of(hburst) - 1;
            else if (htrans == 2'd3 && beats[s] > 0) nb = beats[s] - 1;
            if (lock[own[s]] || nb != 0) nxt = own[s];
            else nxt = pick(s, own[s], req);
            dpm[s] = own[s];
            own[s] = nxt;
            mlk[s] = lock[nxt];
            beats[s] = nb;
         end
      end
   endtask

   task automatic check_outs();
      string r0, r1;
      r0 = (tag == "") ? "R3" : tag;
      r1 = (tag == "") ? "R4" : tag;
      chk(r0, "hmaster static", m0, own[0]);
      chk(r1, "hmaster rotating", m1, own[1]);
      chk("R1", "grant static", g0, 1 << own[0]);
      chk("R1", "grant rotating", g1, 1 << own[1]);
      chk("R6", "hmastlock static", l0, mlk[0]);
      chk("R6", "hmastlock rotating", l1, mlk[1]);
      chk("R9", "dp_master static", d0, dpm[0]);
      chk("R9", "dp_master rotating", d1, dpm[1]);
   endtask

   // drive at a falling edge, check steering, step model, check at next falling edge
   task automatic cyc(input logic [N-1:0] rq, input logic [N-1:0] lk, input logic [1:0] tr,
                      input logic [2:0] hb, input logic rdy, input logic rsp);
      req = rq; lock = lk; htrans = tr; hburst = hb; hready = rdy; hresp = rsp;
      #1;
      chk("R9", "err_to static", e0, (rsp && rdy) ? (1 << dpm[0]) : 0);
      chk("R9", "err_to rotating", e1, (rsp && rdy) ? (1 << dpm[1]) : 0);
      model_step();
      @(negedge clk);
      check_outs();
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1357));
      model_reset();
      repeat (3) @(negedge clk);
      tag = "R1";
      check_outs();                              // R1 reset state
      rst_n = 1'b1;
      @(negedge clk);

      tag = "R5";                                // park on 0 with no requests
      cyc(4'b0100, 0, 0, 0, 1, 0);
      cyc(4'b0000, 0, 0, 0, 1, 0);
      cyc(4'b0000, 0, 0, 0, 1, 0);

      tag = "R2";                                // stalls freeze ownership
      cyc(4'b1000, 0, 0, 0, 0, 0);
      cyc(4'b1000, 0, 0, 0, 0, 0);
      cyc(4'b1000, 0, 0, 0, 1, 0);

      tag = "R3";                                // static ranking
      cyc(4'b1010, 0, 0, 0, 1, 0);
      cyc(4'b1010, 0, 0, 0, 1, 0);
      tag = "R4";                                // rotation among all requesters
      cyc(4'b1111, 0, 0, 0, 1, 0);
      cyc(4'b1111, 0, 0, 0, 1, 0);
      cyc(4'b1111, 0, 0, 0, 1, 0);
      cyc(4'b1111, 0, 0, 0, 1, 0);

      tag = "R7";                                // 4-beat burst held by manager 2
      cyc(4'b0100, 0, 0, 0, 1, 0);
      cyc(4'b0101, 0, 2, 3'd3, 1, 0);
      cyc(4'b0101, 0, 3, 3'd3, 1, 0);
      cyc(4'b0101, 0, 3, 3'd3, 0, 0);
      cyc(4'b0101, 0, 3, 3'd3, 1, 0);
      cyc(4'b0101, 0, 3, 3'd3, 1, 0);
      cyc(4'b0101, 0, 0, 0, 1, 0);

      tag = "R8";                                // error cuts an 8-beat burst short
      cyc(4'b0100, 0, 0, 0, 1, 0);
      cyc(4'b0101, 0, 2, 3'd5, 1, 0);
      cyc(4'b0101, 0, 3, 3'd5, 1, 0);
      cyc(4'b0101, 0, 3, 3'd5, 0, 1);
      cyc(4'b0101, 0, 3, 3'd5, 1, 1);
      cyc(4'b0101, 0, 0, 0, 1, 0);

      tag = "R6";                                // lock keeps manager 3
      cyc(4'b1000, 4'b1000, 0, 0, 1, 0);
      cyc(4'b1001, 4'b1000, 0, 0, 1, 0);
      cyc(4'b1001, 4'b1000, 0, 0, 1, 0);
      cyc(4'b0001, 4'b0000, 0, 0, 1, 0);

      tag = "";
      for (int n = 0; n < 3000; n++) begin
         logic [N-1:0] rq, lk;
         rq = N'($urandom);
         lk = ($urandom % 8 == 0) ? (N'(1) << ($urandom % N)) : '0;
         cyc(rq, lk, 2'($urandom), 3'($urandom), ($urandom % 4) != 0, ($urandom % 10) == 0);
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule